// File: doc/BRIEF.md
# Mixed-Length Instruction Prefetch Buffer

This block is the fetch front end of a small in-order core. It reads instruction memory one 32-bit word at a time and keeps the returned words in a three-word queue. From that queue it presents one instruction per cycle to the decode stage. An instruction is 16 or 32 bits long, and its length is known from its first halfword. A 32-bit instruction may start in the upper half of one word and end in the lower half of the next. The block joins the two halves and issues the instruction as one unit, with its program counter.

Fetching goes on while decode consumes. Requests are throttled so the queue can never overflow, even counting the words still in flight. Decode can hold the current instruction with a stall input. A redirect input flushes the queue and discards the responses still in flight. Fetch then restarts at the word that holds the new halfword-aligned target.

Top module: `insn_prefetch`

## Requirements
- R1: While reset is high, `dec_valid` is low. In the first cycle after reset, a fetch request for address `RESET_PC` is presented.
- R2: Every fetch request address is word aligned (bits 1:0 zero). Apart from a redirect, each accepted request is for the address 4 above the previously accepted one.
- R3: A first halfword whose bits 15:13 are all ones and whose bits 12:11 are not 00 starts a 32-bit instruction. Any other value, including 111 followed by 00, starts a 16-bit instruction. `dec_is_long` reports the result.
- R4: The halfword at byte address 4k is bits 15:0 of the word fetched from 4k, and the halfword at 4k+2 is bits 31:16. A 16-bit instruction is presented as {16'h0000, halfword}. A 32-bit instruction is presented as {first halfword, second halfword}.
- R5: A 32-bit instruction whose second halfword has not yet arrived is not presented. `dec_valid` stays low until the next word is in the queue.
- R6: Each instruction taken by decode (`dec_valid` high, `dec_stall` low) advances `dec_pc` by 2 for a 16-bit instruction or by 4 for a 32-bit one, in the next cycle.
- R7: While `dec_stall` is high, the presented instruction, length flag and PC stay unchanged and nothing is removed from the queue.
- R8: A request is made only if at least two free halfword slots of the queue (three words, six halfwords) remain once all pending live responses have landed. No more than `MAX_INFLIGHT` requests are ever outstanding. If decode stalls forever after a redirect, exactly three words are fetched.
- R9: A redirect sets `dec_pc` to the target in the next cycle and makes the next request address the word containing the target. When the target is the upper halfword, the lower halfword of that word is skipped. Responses to requests accepted before the redirect, or arriving in the redirect cycle, are discarded.
- R10: In a redirect cycle, `dec_valid` and `mem_req_valid` are both low.
- R11: Instructions leave the block strictly in program order, with none lost, duplicated or invented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Fetch request present |
| mem_req_addr | output | ADDR_W | Word-aligned fetch address |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Response word present (in request order) |
| mem_rsp_data | input | 32 | Response word |
| dec_valid | output | 1 | An instruction is presented to decode |
| dec_insn | output | 32 | Presented instruction |
| dec_is_long | output | 1 | High for a 32-bit instruction |
| dec_pc | output | ADDR_W | Address of the presented instruction |
| dec_stall | input | 1 | Decode does not take the instruction this cycle |
| redir_valid | input | 1 | Flush and restart fetch |
| redir_pc | input | ADDR_W | Halfword-aligned restart address |

## Verification
A response word latched at a clock edge can make an instruction visible on the decode outputs within that same following cycle, since the outputs are combinational on the queue registers. A taken instruction moves `dec_pc` one edge later, and a redirect shows its fetch address and PC one edge after the redirect cycle. The bench drives every input 2.5 ns before a rising edge. It samples 1 ns later, after the inputs have settled but before the edge, and decides from those samples which request and which instruction the coming edge takes. The expected instruction stream is rebuilt from the target on every redirect, and each taken instruction is compared in that same cycle. A stalled instruction is compared again in the following cycle.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t bits;
        logic  is_long;
    } issue_slot_t;

    // Extended form: top three bits set and the next two bits not both zero.
    function automatic logic hw_is_long(half_t h);
        return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
    endfunction

    function automatic issue_slot_t assemble(half_t first, half_t second);
        issue_slot_t r;
        r.is_long = hw_is_long(first);
        r.bits    = r.is_long ? {first, second} : {16'h0000, first};
        return r;
    endfunction

endpackage

// File: rtl/pfb_hw_queue.sv
module pfb_hw_queue
    import pfb_pkg::*;
#(
    parameter int DEPTH_WORDS = 3,
    localparam int SLOTS = 2 * DEPTH_WORDS,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int WP_W  = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             flush_skip,
    input  logic             push,
    input  word_t            push_word,
    input  logic             pop,
    input  logic             pop_long,
    output logic [CNT_W-1:0] fill,
    output half_t            head0,
    output half_t            head1
);

    logic [SLOTS-1:0][HALF_W-1:0] hw_view;
    logic [WP_W-1:0]  wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] fill_q;
    logic             skip_q;
    logic             skip_now;
    int               adv;

    function automatic logic [PTR_W-1:0] rd_add(logic [PTR_W-1:0] p, int k);
        int s;
        s = int'(p) + k;
        if (s >= SLOTS) s = s - SLOTS;
        return PTR_W'(s);
    endfunction

    // One storage word per queue entry, viewed as two halfword slots.
    for (genvar w = 0; w < DEPTH_WORDS; w++) begin : g_word
        word_t word_q;
        always_ff @(posedge clk) begin
            if (push && !flush && (int'(wr_q) == w)) word_q <= push_word;
        end
        assign hw_view[2*w]   = word_q[15:0];
        assign hw_view[2*w+1] = word_q[31:16];
    end

    always_comb begin
        skip_now = push && skip_q;
        adv      = (pop ? (pop_long ? 2 : 1) : 0) + (skip_now ? 1 : 0);
        head0    = hw_view[rd_q];
        head1    = hw_view[rd_add(rd_q, 1)];
        fill     = fill_q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
            skip_q <= rst ? 1'b0 : flush_skip;
        end else begin
            if (push) begin
                wr_q   <= (wr_q == WP_W'(DEPTH_WORDS - 1)) ? '0 : wr_q + 1'b1;
                skip_q <= 1'b0;
            end
            rd_q   <= rd_add(rd_q, adv);
            fill_q <= CNT_W'(int'(fill_q) + (push ? 2 : 0) - adv);
        end
    end

endmodule

// File: rtl/pfb_fetch_ctl.sv
module pfb_fetch_ctl
    import pfb_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DEPTH_WORDS  = 3,
    parameter int MAX_INFLIGHT = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    localparam int CNT_W = $clog2(2 * DEPTH_WORDS + 1),
    localparam int IF_W  = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_pc,
    input  logic [CNT_W-1:0]  fill,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    output logic              push
);

    localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};

    logic [ADDR_W-1:0] fetch_q;
    logic [IF_W-1:0]   inflight_q;
    logic [IF_W-1:0]   drop_q;
    logic              fire;
    int                space;

    always_comb begin
        // Halfword slots left once every live response has landed.
        space         = 2 * DEPTH_WORDS - int'(fill)
                        - 2 * (int'(inflight_q) - int'(drop_q));
        mem_req_valid = !redirect && (space >= 2) && (int'(inflight_q) < MAX_INFLIGHT);
        mem_req_addr  = fetch_q;
        fire          = mem_req_valid && mem_req_ready;
        push          = mem_rsp_valid && (drop_q == '0) && !redirect;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q    <= RESET_PC & WORD_MASK;
            inflight_q <= '0;
            drop_q     <= '0;
        end else begin
            inflight_q <= inflight_q + IF_W'(fire) - IF_W'(mem_rsp_valid);
            if (redirect) begin
                fetch_q <= redirect_pc & WORD_MASK;
                drop_q  <= inflight_q - IF_W'(mem_rsp_valid);
            end else begin
                if (fire) fetch_q <= fetch_q + ADDR_W'(4);
                if (mem_rsp_valid && (drop_q != '0)) drop_q <= drop_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfb_issue.sv
module pfb_issue
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 3,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  half_t             head0,
    input  half_t             head1,
    input  logic [CNT_W-1:0]  fill,
    input  logic              stall,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_pc,
    output logic              dec_valid,
    output word_t             dec_insn,
    output logic              dec_is_long,
    output logic [ADDR_W-1:0] dec_pc,
    output logic              pop,
    output logic              pop_long
);

    localparam logic [ADDR_W-1:0] HALF_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

    issue_slot_t       slot;
    logic              complete;
    logic [ADDR_W-1:0] pc_q;

    always_comb begin
        slot        = assemble(head0, head1);
        complete    = slot.is_long ? (fill >= CNT_W'(2)) : (fill >= CNT_W'(1));
        dec_valid   = complete && !redirect;
        dec_insn    = slot.bits;
        dec_is_long = slot.is_long;
        dec_pc      = pc_q;
        pop         = dec_valid && !stall;
        pop_long    = slot.is_long;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC & HALF_MASK;
        end else if (redirect) begin
            pc_q <= redirect_pc & HALF_MASK;
        end else if (pop) begin
            pc_q <= pc_q + (slot.is_long ? ADDR_W'(4) : ADDR_W'(2));
        end
    end

endmodule

// File: rtl/insn_prefetch.sv
module insn_prefetch
    import pfb_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DEPTH_WORDS  = 3,
    parameter int MAX_INFLIGHT = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              dec_valid,
    output logic [31:0]       dec_insn,
    output logic              dec_is_long,
    output logic [ADDR_W-1:0] dec_pc,
    input  logic              dec_stall,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc
);

    localparam int CNT_W = $clog2(2 * DEPTH_WORDS + 1);

    logic [CNT_W-1:0] fill;
    half_t            head0;
    half_t            head1;
    logic             push;
    logic             pop;
    logic             pop_long;

    pfb_fetch_ctl #(
        .ADDR_W      (ADDR_W),
        .DEPTH_WORDS (DEPTH_WORDS),
        .MAX_INFLIGHT(MAX_INFLIGHT),
        .RESET_PC    (RESET_PC)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .redirect     (redir_valid),
        .redirect_pc  (redir_pc),
        .fill         (fill),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .push         (push)
    );

    pfb_hw_queue #(
        .DEPTH_WORDS(DEPTH_WORDS)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (redir_valid),
        .flush_skip(redir_pc[1]),
        .push      (push),
        .push_word (mem_rsp_data),
        .pop       (pop),
        .pop_long  (pop_long),
        .fill      (fill),
        .head0     (head0),
        .head1     (head1)
    );

    pfb_issue #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .RESET_PC(RESET_PC)
    ) u_issue (
        .clk        (clk),
        .rst        (rst),
        .head0      (head0),
        .head1      (head1),
        .fill       (fill),
        .stall      (dec_stall),
        .redirect   (redir_valid),
        .redirect_pc(redir_pc),
        .dec_valid  (dec_valid),
        .dec_insn   (dec_insn),
        .dec_is_long(dec_is_long),
        .dec_pc     (dec_pc),
        .pop        (pop),
        .pop_long   (pop_long)
    );

endmodule

// File: rtl/insn_prefetch_chk.sv
module insn_prefetch_chk #(
    parameter int ADDR_W       = 32,
    parameter int MAX_INFLIGHT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              mem_rsp_valid,
    input logic [31:0]       mem_rsp_data,
    input logic              dec_valid,
    input logic [31:0]       dec_insn,
    input logic              dec_is_long,
    input logic [ADDR_W-1:0] dec_pc,
    input logic              dec_stall,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_pc
);

    localparam int OC_W = $clog2(MAX_INFLIGHT + 2) + 1;

    logic              req_fire;
    logic              seen_q;
    logic [ADDR_W-1:0] last_q;
    logic [OC_W-1:0]   out_q;

    assign req_fire = mem_req_valid && mem_req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            last_q <= '0;
            out_q  <= '0;
        end else begin
            out_q <= out_q + OC_W'(req_fire) - OC_W'(mem_rsp_valid);
            if (redir_valid) begin
                seen_q <= 1'b0;
            end else if (req_fire) begin
                seen_q <= 1'b1;
                last_q <= mem_req_addr;
            end
        end
    end

    assert_req_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    assert_req_sequential_R2: assert property (@(posedge clk) disable iff (rst)
        (req_fire && seen_q) |-> (mem_req_addr == last_q + ADDR_W'(4)));

    assert_len_rule_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_is_long
            ? ((dec_insn[31:29] == 3'b111) && (dec_insn[28:27] != 2'b00))
            : ((dec_insn[31:16] == 16'h0000) &&
               !((dec_insn[15:13] == 3'b111) && (dec_insn[12:11] != 2'b00)))));

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_stall) |=>
            (dec_pc == $past(dec_pc) + ($past(dec_is_long) ? ADDR_W'(4) : ADDR_W'(2))));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_stall) |=>
            (redir_valid || (dec_valid && $stable(dec_insn) && $stable(dec_pc)
                             && $stable(dec_is_long))));

    assert_inflight_cap_R8: assert property (@(posedge clk) disable iff (rst)
        int'(out_q) <= MAX_INFLIGHT);

    assert_redir_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (mem_req_addr == {$past(redir_pc[ADDR_W-1:2]), 2'b00}));

    assert_redir_pc_R9: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (dec_pc == {$past(redir_pc[ADDR_W-1:1]), 1'b0}));

    assert_redir_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (!dec_valid && !mem_req_valid));

endmodule

bind insn_prefetch insn_prefetch_chk #(
    .ADDR_W      (ADDR_W),
    .MAX_INFLIGHT(MAX_INFLIGHT)
) u_chk (.*);

// File: tb/test_insn_prefetch.sv
`timescale 1ns/100ps
module test_insn_prefetch;

    localparam int AW    = 32;
    localparam int DEPTH = 3;
    localparam int MAXF  = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready;
    logic          mem_rsp_valid;
    logic [31:0]   mem_rsp_data;
    logic          dec_valid;
    logic [31:0]   dec_insn;
    logic          dec_is_long;
    logic [AW-1:0] dec_pc;
    logic          dec_stall;
    logic          redir_valid;
    logic [AW-1:0] redir_pc;

    always #2.5 clk = ~clk;

    insn_prefetch #(
        .ADDR_W(AW), .DEPTH_WORDS(DEPTH), .MAX_INFLIGHT(MAXF), .RESET_PC('0)
    ) i_insn_prefetch (
        .clk(clk), .rst(rst),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .dec_valid(dec_valid), .dec_insn(dec_insn),
        .dec_is_long(dec_is_long), .dec_pc(dec_pc), .dec_stall(dec_stall),
        .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    typedef struct { logic [31:0] insn; logic lng; logic [31:0] pc; } exp_t;
    typedef struct { logic [31:0] addr; int due; } rsp_t;

    exp_t        sb[$];
    rsp_t        mq[$];
    int          n_chk = 0, n_fail = 0, cyc = 0;
    int          lat = 1, budget = -1, rdy_mode = 0, stall_mode = 0;
    int          outstanding = 0, req_count = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        pend_redir = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [31:0] exp_fetch = '0;
    logic        first_after = 1'b1;
    logic        prev_hold = 1'b0;
    logic [31:0] prev_insn, prev_pc;
    logic        prev_long;

    // Program image: halfword content is a function of its address.
    function automatic logic [15:0] hw_at(logic [31:0] a);
        int k;
        logic [15:0] r;
        k = int'(a[16:1]);
        r = 16'(k * 40503) ^ 16'(k << 5);
        case (k % 3)
            0:       r[15:11] = 5'b11101;
            1:       r[15:11] = 5'b11100;
            default: r[15]    = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_long_hw(logic [15:0] h);
        return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
    endfunction

    function automatic logic [31:0] word_at(logic [31:0] a);
        return {hw_at(a + 32'd2), hw_at(a)};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected stream from a start address.
    task automatic load_expect(logic [31:0] start, int n);
        logic [31:0] pc;
        logic [15:0] h;
        exp_t e;
        sb.delete();
        pc = start & 32'hFFFF_FFFE;
        for (int i = 0; i < n; i++) begin
            h = hw_at(pc);
            e.pc = pc;
            if (is_long_hw(h)) begin
                e.insn = {h, hw_at(pc + 32'd2)}; e.lng = 1'b1; pc = pc + 32'd4;
            end else begin
                e.insn = {16'h0000, h}; e.lng = 1'b0; pc = pc + 32'd2;
            end
            sb.push_back(e);
        end
        first_after = 1'b1;
    endtask

    task automatic step();
        exp_t e;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (mq.size() > 0 && mq[0].due <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = word_at(mq[0].addr);
            void'(mq.pop_front());
            outstanding--;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
        end
        mem_req_ready = (budget != 0) && (rdy_mode == 0 || lfsr[3:2] != 2'b00);
        dec_stall = (stall_mode == 2) ? 1'b1 : (stall_mode == 1) ? (lfsr[7] & lfsr[5]) : 1'b0;
        redir_valid = pend_redir;
        redir_pc    = pend_addr;
        pend_redir  = 1'b0;
        #1;
        if (redir_valid) begin
            check(!dec_valid && !mem_req_valid, "R10", "quiet in redirect cycle",
                  {dec_valid, mem_req_valid}, 0);
            load_expect(redir_pc, 400);
            exp_fetch = redir_pc & 32'hFFFF_FFFC;
            prev_hold = 1'b0;
        end else begin
            if (prev_hold) begin
                check(dec_valid && dec_insn == prev_insn && dec_pc == prev_pc
                      && dec_is_long == prev_long, "R7", "held under stall",
                      {dec_valid, dec_insn}, {1'b1, prev_insn});
            end
            if (dec_valid && !dec_stall) begin
                if (sb.size() == 0) begin
                    check(0, "R11", "unexpected instruction", dec_insn, 0);
                end else begin
                    e = sb.pop_front();
                    check(dec_insn == e.insn, "R4", "instruction bits", dec_insn, e.insn);
                    check(dec_is_long == e.lng, "R3", "length flag", dec_is_long, e.lng);
                    check(dec_pc == e.pc, first_after ? "R9" : "R6", "pc", dec_pc, e.pc);
                    first_after = 1'b0;
                end
            end
            prev_hold = dec_valid && dec_stall;
            prev_insn = dec_insn;
            prev_pc   = dec_pc;
            prev_long = dec_is_long;
            if (mem_req_valid && mem_req_ready) begin
                check(mem_req_addr == exp_fetch, "R2", "fetch address", mem_req_addr, exp_fetch);
                exp_fetch = exp_fetch + 32'd4;
                mq.push_back('{addr: mem_req_addr, due: cyc + lat});
                outstanding++;
                req_count++;
                check(outstanding <= MAXF, "R8", "outstanding requests", outstanding, MAXF);
                if (budget > 0) budget--;
            end
        end
        cyc++;
    endtask

    task automatic do_redirect(logic [31:0] a);
        pend_redir = 1'b1;
        pend_addr  = a;
        step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] t;
        rst = 1'b1;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        dec_stall = 1'b0; redir_valid = 1'b0; redir_pc = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1 check(!dec_valid, "R1", "dec_valid in reset", dec_valid, 0);
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(mem_req_valid && mem_req_addr == 32'h0, "R1", "first request after reset",
              {mem_req_valid, mem_req_addr}, {1'b1, 32'h0});
        load_expect(32'h0, 400);
        exp_fetch = 32'h0;

        // Plain streaming, short latency.
        lat = 1;
        repeat (150) step();

        // Longer latency, random ready and random stalls.
        lat = 3; rdy_mode = 1; stall_mode = 1;
        repeat (300) step();

        // Redirect with responses in flight, even target.
        do_redirect(32'h0000_0100);
        repeat (200) step();

        // Redirect to an upper halfword holding a 16-bit instruction.
        t = 32'h0000_0502;
        while (is_long_hw(hw_at(t))) t = t + 32'd4;
        do_redirect(t);
        repeat (100) step();

        // Straddling 32-bit instruction must wait for its second word.
        rdy_mode = 0; stall_mode = 0; lat = 2;
        t = 32'h0000_0302;
        while (!is_long_hw(hw_at(t))) t = t + 32'd4;
        budget = 1;
        do_redirect(t);
        repeat (12) step();
        check(!dec_valid, "R5", "straddle held back", dec_valid, 0);
        budget = -1;
        repeat (60) step();

        // Capacity with decode stalled forever.
        stall_mode = 2;
        do_redirect(32'h0000_0400);
        req_count = 0;
        repeat (30) step();
        check(req_count == DEPTH, "R8", "words fetched under full stall", req_count, DEPTH);
        stall_mode = 0;
        repeat (80) step();

        // Back-to-back redirects.
        lat = 3; rdy_mode = 1; stall_mode = 1;
        do_redirect(32'h0000_1000);
        do_redirect(32'h0000_2002);
        repeat (150) step();

        finish_run();
    end

endmodule